// File: doc/BRIEF.md
# Indirect-Access Statistics Counter Bank

This block holds a bank of event counters, one per event line, each of which advances by one in every cycle its event input is high. Software cannot address the counters directly. It programs a control register with a starting counter index and an access direction, then moves through the bank by repeated accesses to a single data register. The index steps forward after each accepted data access, so a run of counters can be read or loaded without rewriting the control register.

In read mode a clear-after-read option zeroes each counter once its value has been returned. Software loads and clears are merged with events that arrive in the same cycle, so that no event is lost. The register bus is synchronous: an address, separate read and write strobes, write data, and read data that is registered and valid one cycle after the read strobe.

Top module: `stat_ctr_bank`

## Requirements
- R1: After reset every counter holds zero, the control register reads as zero, and reg_rdata is zero.
- R2: In every cycle in which evt[i] is high, counter i increases by one. A counter holding all ones wraps to zero.
- R3: The control register sits at reg_addr 0 and the data register at reg_addr 1. The control word carries the counter index in bits 5:0, the direction in bit 8 (0 = read, 1 = write), clear-after-read in bit 9 and the key in bit 10. All other bits read as zero. A read returns its value on reg_rdata in the cycle after reg_rd, and reg_rdata is zero in any cycle that does not follow a read.
- R4: A control write with bit 10 clear is discarded and leaves the control word unchanged.
- R5: In read mode, a data-register read returns the counter at the current index and then advances the index by one. The index wraps from 0x3F to 0x00.
- R6: In write mode, a data-register write loads the counter at the current index with reg_wdata and then advances the index by one.
- R7: With clear-after-read set in read mode, the counter that was read holds zero afterwards.
- R8: When a clear-after-read and an event on the same counter fall in the same cycle, the counter holds one afterwards.
- R9: When a data-register write and an event on the same counter fall in the same cycle, the counter holds the written value plus one.
- R10: A data-register read in write mode returns zero and leaves the index unchanged. A data-register write in read mode leaves both the counter and the index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 1 | Register select: 0 control, 1 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| evt | input | 64 | Per-counter event pulses, one bit per counter |

## Verification
A wrong index shows up at the next data read as the value of a neighbouring counter, and on a control readback as wrong bits 5:0. Both are visible one cycle after the strobe. A lost or doubled event, or a clear that does not take effect, stays hidden until that counter is read again, so the bench re-reads each counter after every collision case. A direction decoded the wrong way shows up at once as a nonzero return from a read made in write mode, or as a load that should not have happened.

// File: rtl/stat_ctr_pkg.sv
package stat_ctr_pkg;
  localparam int IDX_LSB  = 0;
  localparam int MODE_BIT = 8;
  localparam int CLR_BIT  = 9;
  localparam int KEY_BIT  = 10;

  typedef enum logic {
    MODE_RD = 1'b0,
    MODE_WR = 1'b1
  } acc_mode_e;
endpackage

// File: rtl/stat_ctr_ctrl.sv
module stat_ctr_ctrl
  import stat_ctr_pkg::*;
#(
  parameter int PTR_W = 6,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_wr,
  input  logic [BUS_W-1:0] ctrl_wdata,
  input  logic             data_rd,
  input  logic             data_wr,
  output logic [PTR_W-1:0] ptr,
  output acc_mode_e        mode,
  output logic             clr_en,
  output logic [BUS_W-1:0] ctrl_word,
  output logic             rd_hit,
  output logic             wr_hit
);
  logic key_q;
  logic load;

  // accepted accesses depend on the stored direction
  always_comb begin
    rd_hit = data_rd && (mode == MODE_RD);
    wr_hit = data_wr && (mode == MODE_WR);
    load   = ctrl_wr && ctrl_wdata[KEY_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= '0;
      mode   <= MODE_RD;
      clr_en <= 1'b0;
      key_q  <= 1'b0;
    end else if (load) begin
      ptr    <= ctrl_wdata[IDX_LSB +: PTR_W];
      mode   <= acc_mode_e'(ctrl_wdata[MODE_BIT]);
      clr_en <= ctrl_wdata[CLR_BIT];
      key_q  <= 1'b1;
    end else if (rd_hit || wr_hit) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_comb begin
    ctrl_word                      = '0;
    ctrl_word[IDX_LSB +: PTR_W]    = ptr;
    ctrl_word[MODE_BIT]            = (mode == MODE_WR);
    ctrl_word[CLR_BIT]             = clr_en;
    ctrl_word[KEY_BIT]             = key_q;
  end
endmodule

// File: rtl/stat_ctr_cell.sv
module stat_ctr_cell #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] base;

  // software action picks the base, the event is always added on top
  always_comb begin
    if (ld)       base = ld_val;
    else if (clr) base = '0;
    else          base = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= base + CNT_W'(evt);
  end
endmodule

// File: rtl/stat_ctr_rdport.sv
module stat_ctr_rdport #(
  parameter int N_CNT = 64,
  parameter int CNT_W = 32,
  parameter int PTR_W = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_ctrl,
  input  logic                   rd_data,
  input  logic [CNT_W-1:0]       ctrl_word,
  input  logic [PTR_W-1:0]       ptr,
  input  logic [N_CNT*CNT_W-1:0] cnt_flat,
  output logic [CNT_W-1:0]       rdata
);
  logic [CNT_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (rd_ctrl)      sel = ctrl_word;
    else if (rd_data) sel = cnt_flat[ptr*CNT_W +: CNT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel;
  end
endmodule

// File: rtl/stat_ctr_bank.sv
module stat_ctr_bank
  import stat_ctr_pkg::*;
#(
  parameter int N_CNT  = 64,
  parameter int CNT_W  = 32,
  parameter int REG_AW = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic [N_CNT-1:0]  evt
);
  localparam int PTR_W = $clog2(N_CNT);
  localparam logic [REG_AW-1:0] CTRL_OFS = REG_AW'(0);
  localparam logic [REG_AW-1:0] DATA_OFS = REG_AW'(1);

  logic             sel_ctrl, sel_data;
  logic [PTR_W-1:0] ptr;
  acc_mode_e        mode;
  logic             mode_is_wr;
  logic             clr_en;
  logic [CNT_W-1:0] ctrl_word;
  logic             rd_hit, wr_hit;
  logic [N_CNT*CNT_W-1:0] cnt_flat;

  always_comb begin
    sel_ctrl   = (reg_addr == CTRL_OFS);
    sel_data   = (reg_addr == DATA_OFS);
    mode_is_wr = (mode == MODE_WR);
  end

  stat_ctr_ctrl #(.PTR_W(PTR_W), .BUS_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .ctrl_wr    (reg_wr && sel_ctrl),
    .ctrl_wdata (reg_wdata),
    .data_rd    (reg_rd && sel_data),
    .data_wr    (reg_wr && sel_data),
    .ptr        (ptr),
    .mode       (mode),
    .clr_en     (clr_en),
    .ctrl_word  (ctrl_word),
    .rd_hit     (rd_hit),
    .wr_hit     (wr_hit)
  );

  for (genvar i = 0; i < N_CNT; i++) begin : g_cell
    logic hit;
    assign hit = (ptr == PTR_W'(i));
    stat_ctr_cell #(.CNT_W(CNT_W)) u_cell (
      .clk    (clk),
      .rst    (rst),
      .evt    (evt[i]),
      .ld     (wr_hit && hit),
      .ld_val (reg_wdata),
      .clr    (rd_hit && clr_en && hit),
      .cnt    (cnt_flat[i*CNT_W +: CNT_W])
    );
  end

  stat_ctr_rdport #(.N_CNT(N_CNT), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_ctrl   (reg_rd && sel_ctrl),
    .rd_data   (rd_hit),
    .ctrl_word (ctrl_word),
    .ptr       (ptr),
    .cnt_flat  (cnt_flat),
    .rdata     (reg_rdata)
  );
endmodule

// File: rtl/stat_ctr_bank_chk.sv
module stat_ctr_bank_chk #(
  parameter int CNT_W  = 32,
  parameter int PTR_W  = 6,
  parameter int REG_AW = 1
) (
  input logic              clk,
  input logic              rst,
  input logic [REG_AW-1:0] reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [CNT_W-1:0]  reg_wdata,
  input logic [CNT_W-1:0]  reg_rdata,
  input logic [PTR_W-1:0]  ptr,
  input logic              mode_wr,
  input logic [CNT_W-1:0]  ctrl_word
);
  localparam logic [REG_AW-1:0] CTRL_OFS = REG_AW'(0);
  localparam logic [REG_AW-1:0] DATA_OFS = REG_AW'(1);

  // R3
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> (reg_rdata == '0));

  // R10
  wrong_mode_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == DATA_OFS && mode_wr) |=> (reg_rdata == '0));

  // R5
  rd_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == DATA_OFS && !mode_wr) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

  // R6
  wr_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == DATA_OFS && mode_wr) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

  // R10
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == DATA_OFS && !(reg_rd && !mode_wr) && !(reg_wr && mode_wr)) |=> $stable(ptr));

  // R4
  key_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == CTRL_OFS && reg_wr && !reg_wdata[10]) |=> $stable(ctrl_word));
endmodule

bind stat_ctr_bank stat_ctr_bank_chk #(.CNT_W(CNT_W), .PTR_W(PTR_W), .REG_AW(REG_AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .ptr       (ptr),
  .mode_wr   (mode_is_wr),
  .ctrl_word (ctrl_word)
);

// File: tb/stat_ctr_bank_bench.sv
module stat_ctr_bank_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [0:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] evt = '0;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  stat_ctr_bank u_stat_ctr_bank (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt(evt)
  );

  // reference state built from the requirements
  logic [31:0] m [64];
  logic [5:0]  mp;
  logic        mmode, mclr, mkey;

  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        seen = 1'b0;

  always @(posedge clk) seen <= reg_rd && !rst;

  // monitor: result of a read is on reg_rdata one cycle later
  always @(negedge clk) begin
    if (seen) begin
      logic [31:0] e;
      string t;
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL %s: unexpected read result got=%h exp=none", "R3", reg_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          bad++;
          $display("FAIL %s: got=%h exp=%h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic step(input logic a, input logic rd, input logic wr,
                      input logic [31:0] wd, input logic [63:0] ev, input string tag);
    logic [31:0] e;
    logic rhit, whit;
    @(negedge clk);
    reg_addr = a; reg_rd = rd; reg_wr = wr; reg_wdata = wd; evt = ev;
    e = '0;
    if (a == 1'b0) e = {21'b0, mkey, mclr, mmode, 2'b00, mp};
    else if (!mmode) e = m[mp];
    rhit = rd && a && !mmode;
    whit = wr && a && mmode;
    for (int i = 0; i < 64; i++) begin
      logic [31:0] nb;
      nb = m[i];
      if (whit && mp == i[5:0]) nb = wd;
      if (rhit && mclr && mp == i[5:0]) nb = '0;
      m[i] = nb + {31'b0, ev[i]};
    end
    if (wr && !a && wd[10]) begin
      mp = wd[5:0]; mmode = wd[8]; mclr = wd[9]; mkey = 1'b1;
    end else if (rhit || whit) begin
      mp = mp + 6'd1;
    end
    if (rd) begin
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
  endtask

  task automatic idle(input logic [63:0] ev);
    step(1'b0, 1'b0, 1'b0, 32'h0, ev, "");
  endtask

  task automatic wctrl(input logic [5:0] idx, input logic wmode, input logic clr);
    step(1'b0, 1'b0, 1'b1, {21'b0, 1'b1, clr, wmode, 2'b00, idx}, '0, "");
  endtask

  task automatic rctrl(input string tag);
    step(1'b0, 1'b1, 1'b0, 32'h0, '0, tag);
  endtask

  task automatic rdat(input logic [63:0] ev, input string tag);
    step(1'b1, 1'b1, 1'b0, 32'h0, ev, tag);
  endtask

  task automatic wdat(input logic [31:0] v, input logic [63:0] ev, input string tag);
    step(1'b1, 1'b0, 1'b1, v, ev, tag);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: got=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) m[i] = '0;
    mp = '0; mmode = 1'b0; mclr = 1'b0; mkey = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state
    rctrl("R1");
    rdat('0, "R1");

    // R2: event patterns on low counters
    repeat (3) idle(64'h0000_0000_0000_000F);
    repeat (2) idle(64'h0000_0000_0000_0005);
    idle(64'h8000_0000_0000_0002);
    // R5: sweep read from index 0, with an event coinciding on counter 1
    wctrl(6'd0, 1'b0, 1'b0);
    rctrl("R3");
    rdat('0, "R5");
    rdat(64'h2, "R5");
    rdat('0, "R5");
    rdat('0, "R5");
    wctrl(6'd1, 1'b0, 1'b0);
    rdat('0, "R2");

    // R6: write mode, wrap 0x3F -> 0x00
    wctrl(6'h3E, 1'b1, 1'b0);
    wdat(32'hFFFF_FFFF, '0, "R6");
    wdat(32'h0000_0123, '0, "R6");
    wdat(32'h0000_0007, '0, "R6");
    rctrl("R5");
    // R10: read in write mode returns zero, index held
    rdat('0, "R10");
    rctrl("R10");

    // R2: wrap of an all-ones counter
    idle(64'h4000_0000_0000_0000);
    wctrl(6'h3E, 1'b0, 1'b0);
    rdat('0, "R2");
    rdat('0, "R6");
    rdat('0, "R5");

    // R9: write with coincident event
    wctrl(6'd5, 1'b1, 1'b0);
    wdat(32'd100, 64'h20, "R9");
    wdat(32'd40, '0, "R6");

    // R8, R7: clear after read
    wctrl(6'd5, 1'b0, 1'b1);
    rctrl("R3");
    rdat(64'h20, "R8");
    rdat('0, "R7");
    wctrl(6'd5, 1'b0, 1'b0);
    rdat('0, "R8");
    rdat('0, "R7");

    // R10: write in read mode ignored
    wctrl(6'd2, 1'b0, 1'b0);
    wdat(32'hDEAD_BEEF, '0, "R10");
    rctrl("R10");
    rdat('0, "R10");

    // R4: keyless control write discarded
    step(1'b0, 1'b0, 1'b1, 32'h0000_0305, '0, "");
    rctrl("R4");

    repeat (3) idle('0);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R3: pending reads got=%0d exp=0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule